// File: doc/BRIEF.md
# Dual-Core System Request Arbiter

This block sits between two processor cores and a single shared system interface. Each core pushes outbound transactions of four kinds into its own set of queues: reads, explicit writes (an address entry paired with a data buffer), implicit writebacks (data held in the two spare data buffers) and clean castouts. The arbiter picks one transaction per cycle for a registered issue slot that drives a valid/ready port. It alternates strictly between the cores when both have work. Within a core, it orders the kinds by a fixed priority. Whenever a queue entry leaves, the arbiter sends a one-credit pulse back to the owning core and names the kind that was freed.

In the inbound direction, the block steers data responses to the core whose identity travels in the top bit of the response tag. It copies broadcast messages to both cores. Snoops go to both cores as well. A small state machine (states `SN_IDLE`, `SN_WAIT`, `SN_EMIT`) collects both per-core snoop replies and produces one merged reply for the socket. The issue slot has its own machine (states `IS_EMPTY`, `IS_HELD`). Its transitions are: load (`IS_EMPTY`→`IS_HELD` when any queue is non-empty), accept (`IS_HELD`→`IS_EMPTY` when the port is ready and nothing is left to load) and accept-and-reload (`IS_HELD`→`IS_HELD`). The snoop machine moves on accept (`SN_IDLE`→`SN_WAIT`), on both replies seen (`SN_WAIT`→`SN_EMIT`) and on emit (`SN_EMIT`→`SN_IDLE`). Everything runs on one clock.

Top module: `dual_core_sys_arbiter`

## Requirements
- R1: Per core the queues hold 4 reads, 2 explicit writes, 4 castouts and 2 implicit writebacks (4 data buffers minus the 2 used by writes). Kind codes on `push_kind`/`out_kind`/`crd_kind` are 0 read, 1 write, 2 castout, 3 implicit writeback. Core c uses bits [2c+1:2c] of each packed kind field and the c-th slice of the other packed fields.
- R2: Within one core, reads issue before explicit writes, explicit writes before implicit writebacks, and implicit writebacks before castouts.
- R3: When both cores hold pending transactions, consecutive loads of the issue slot alternate between the cores, one for one.
- R4: A core that is the only one with pending work loads the slot on consecutive opportunities.
- R5: While `out_valid` is high and `out_ready` is low, the issue slot contents stay unchanged. A transaction leaves on a cycle with both high. The slot reloads in that same cycle if work remains.
- R6: In the cycle after a queue entry moves into the issue slot, `crd_valid[c]` of the owning core pulses for one cycle, and `crd_kind` carries the freed kind.
- R7: A push into a full queue is dropped and sets that core's `ovf_err` bit, which stays set until reset.
- R8: A response with tag bit TAG_W equal to c appears one cycle later on `core_rsp_valid[c]` only, with the low tag bits and the data unchanged.
- R9: A broadcast appears one cycle later on both bits of `core_bc_valid` with its code.
- R10: An accepted snoop (`snp_valid` while `snp_ready`) is forwarded to both cores in the next cycle. `snp_ready` stays low until the merged reply has been emitted.
- R11: The merged reply `sock_valid` pulses for one cycle, only after both cores have replied. `sock_hit` is the OR of the hits and `sock_mod` is the OR of the modified flags.
- R12: After reset, every valid, credit, error and snoop output is low and `snp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| push_valid | input | 2 | Per-core push strobe |
| push_kind | input | 4 | Per-core transaction kind |
| push_addr | input | 2*ADDR_W | Per-core address |
| push_data | input | 2*DATA_W | Per-core write data |
| push_tag | input | 2*TAG_W | Per-core request tag |
| crd_valid | output | 2 | Per-core one-credit return pulse |
| crd_kind | output | 4 | Kind of the freed entry |
| ovf_err | output | 2 | Sticky per-core overflow flag |
| out_valid | output | 1 | Issue slot holds a transaction |
| out_ready | input | 1 | System interface accepts the slot |
| out_core | output | 1 | Originating core |
| out_kind | output | 2 | Transaction kind |
| out_addr | output | ADDR_W | Address |
| out_data | output | DATA_W | Write data |
| out_tag | output | TAG_W | Core's request tag |
| rsp_valid | input | 1 | Inbound response strobe |
| rsp_tag | input | TAG_W+1 | Core id in top bit, tag below |
| rsp_data | input | DATA_W | Response data |
| core_rsp_valid | output | 2 | Per-core response strobe |
| core_rsp_tag | output | TAG_W | Steered tag |
| core_rsp_data | output | DATA_W | Steered data |
| bc_valid | input | 1 | Broadcast strobe |
| bc_code | input | BC_W | Broadcast message code |
| core_bc_valid | output | 2 | Per-core broadcast strobe |
| core_bc_code | output | BC_W | Broadcast code to cores |
| snp_valid | input | 1 | Inbound snoop strobe |
| snp_ready | output | 1 | Snoop merger idle |
| snp_addr | input | ADDR_W | Snoop address |
| core_snp_valid | output | 2 | Snoop forward strobe |
| core_snp_addr | output | ADDR_W | Forwarded snoop address |
| csr_valid | input | 2 | Per-core snoop reply strobe |
| csr_hit | input | 2 | Per-core hit flag |
| csr_mod | input | 2 | Per-core modified flag |
| sock_valid | output | 1 | Merged snoop reply strobe |
| sock_hit | output | 1 | Merged hit |
| sock_mod | output | 1 | Merged modified |

## Verification
The assertions assume that each core replies to a forwarded snoop at most once and only while the merger waits. They also assume that the system interface follows valid/ready, so a held slot is never replaced. The stimulus sends core replies only after the forward pulse, and it lowers `out_ready` only between accepted transfers. It breaks the credit rule on purpose in exactly one directed test. That test checks the sticky flag and the dropped entry at the ports, and no assertion relies on the credit rule.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_CORES = 2;
    localparam int NUM_KINDS = 4;

    localparam logic [1:0] K_READ  = 2'd0;
    localparam logic [1:0] K_WRITE = 2'd1;
    localparam logic [1:0] K_CAST  = 2'd2;
    localparam logic [1:0] K_IWB   = 2'd3;

    typedef enum logic {
        IS_EMPTY,
        IS_HELD
    } issue_state_e;

    typedef enum logic [1:0] {
        SN_IDLE,
        SN_WAIT,
        SN_EMIT
    } snoop_state_e;
endpackage

// File: rtl/arb_fifo.sv
module arb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic [CW-1:0]    cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)
                cnt <= cnt + 1'b1;
            else if (pop && !push)
                cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= din;
    end
endmodule

// File: rtl/arb_core_queues.sv
module arb_core_queues
    import arb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4,
    parameter int RDQ_DEPTH = 4,
    parameter int WRQ_DEPTH = 2,
    parameter int COQ_DEPTH = 4,
    parameter int WDB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [1:0]        push_kind,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic              pop,
    output logic              head_valid,
    output logic [1:0]        head_kind,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic              crd_valid,
    output logic [1:0]        crd_kind,
    output logic              ovf
);
    localparam int PW        = ADDR_W + DATA_W + TAG_W;
    localparam int IWB_DEPTH = WDB_DEPTH - WRQ_DEPTH;

    logic [NUM_KINDS-1:0] q_empty;
    logic [NUM_KINDS-1:0] q_full;
    logic [NUM_KINDS-1:0] q_push;
    logic [NUM_KINDS-1:0] q_pop;
    logic [PW-1:0]        q_dout [NUM_KINDS];
    logic [PW-1:0]        din;

    assign din = {push_addr, push_data, push_tag};

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_q
        localparam int DEP = (k == 0) ? RDQ_DEPTH :
                             (k == 1) ? WRQ_DEPTH :
                             (k == 2) ? COQ_DEPTH : IWB_DEPTH;
        assign q_push[k] = push_valid && (push_kind == 2'(k)) && !q_full[k];
        assign q_pop[k]  = pop && head_valid && (head_kind == 2'(k));
        arb_fifo #(
            .WIDTH(PW),
            .DEPTH(DEP)
        ) u_fifo (
            .clk  (clk),
            .rst_n(rst_n),
            .push (q_push[k]),
            .din  (din),
            .pop  (q_pop[k]),
            .dout (q_dout[k]),
            .empty(q_empty[k]),
            .full (q_full[k])
        );
    end

    // fixed order: read, explicit write, implicit writeback, castout
    always_comb begin
        head_kind = K_CAST;
        if (!q_empty[K_READ])
            head_kind = K_READ;
        else if (!q_empty[K_WRITE])
            head_kind = K_WRITE;
        else if (!q_empty[K_IWB])
            head_kind = K_IWB;
    end

    assign head_valid = ~&q_empty;
    assign {head_addr, head_data, head_tag} = q_dout[head_kind];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf       <= 1'b0;
            crd_valid <= 1'b0;
            crd_kind  <= K_READ;
        end else begin
            if (push_valid && q_full[push_kind])
                ovf <= 1'b1;
            crd_valid <= pop && head_valid;
            crd_kind  <= head_kind;
        end
    end
endmodule

// File: rtl/arb_snoop_merge.sv
module arb_snoop_merge
    import arb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ready,
    output logic [1:0]        core_snp_valid,
    output logic [ADDR_W-1:0] core_snp_addr,
    input  logic [1:0]        csr_valid,
    input  logic [1:0]        csr_hit,
    input  logic [1:0]        csr_mod,
    output logic              sock_valid,
    output logic              sock_hit,
    output logic              sock_mod
);
    snoop_state_e state, state_n;
    logic [1:0]   got;
    logic [1:0]   got_n;
    logic         hit_acc;
    logic         mod_acc;
    logic         fwd;

    assign got_n = got | csr_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SN_IDLE;
        else
            state <= state_n;
    end

    always_comb begin
        state_n    = state;
        snp_ready  = 1'b0;
        sock_valid = 1'b0;
        unique case (state)
            SN_IDLE: begin
                snp_ready = 1'b1;
                if (snp_valid)
                    state_n = SN_WAIT;
            end
            SN_WAIT: begin
                if (&got_n)
                    state_n = SN_EMIT;
            end
            SN_EMIT: begin
                sock_valid = 1'b1;
                state_n    = SN_IDLE;
            end
            default: state_n = SN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got           <= '0;
            hit_acc       <= 1'b0;
            mod_acc       <= 1'b0;
            fwd           <= 1'b0;
            core_snp_addr <= '0;
        end else begin
            fwd <= (state == SN_IDLE) && snp_valid;
            if ((state == SN_IDLE) && snp_valid) begin
                got           <= '0;
                hit_acc       <= 1'b0;
                mod_acc       <= 1'b0;
                core_snp_addr <= snp_addr;
            end else if (state == SN_WAIT) begin
                got     <= got_n;
                hit_acc <= hit_acc | |(csr_valid & csr_hit);
                mod_acc <= mod_acc | |(csr_valid & csr_mod);
            end
        end
    end

    assign core_snp_valid = {fwd, fwd};
    assign sock_hit       = sock_valid & hit_acc;
    assign sock_mod       = sock_valid & mod_acc;
endmodule

// File: rtl/dual_core_sys_arbiter.sv
module dual_core_sys_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4,
    parameter int BC_W      = 4,
    parameter int RDQ_DEPTH = 4,
    parameter int WRQ_DEPTH = 2,
    parameter int COQ_DEPTH = 4,
    parameter int WDB_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CORES-1:0]         push_valid,
    input  logic [2*NUM_CORES-1:0]       push_kind,
    input  logic [NUM_CORES*ADDR_W-1:0]  push_addr,
    input  logic [NUM_CORES*DATA_W-1:0]  push_data,
    input  logic [NUM_CORES*TAG_W-1:0]   push_tag,
    output logic [NUM_CORES-1:0]         crd_valid,
    output logic [2*NUM_CORES-1:0]       crd_kind,
    output logic [NUM_CORES-1:0]         ovf_err,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic                         out_core,
    output logic [1:0]                   out_kind,
    output logic [ADDR_W-1:0]            out_addr,
    output logic [DATA_W-1:0]            out_data,
    output logic [TAG_W-1:0]             out_tag,
    input  logic                         rsp_valid,
    input  logic [TAG_W:0]               rsp_tag,
    input  logic [DATA_W-1:0]            rsp_data,
    output logic [NUM_CORES-1:0]         core_rsp_valid,
    output logic [TAG_W-1:0]             core_rsp_tag,
    output logic [DATA_W-1:0]            core_rsp_data,
    input  logic                         bc_valid,
    input  logic [BC_W-1:0]              bc_code,
    output logic [NUM_CORES-1:0]         core_bc_valid,
    output logic [BC_W-1:0]              core_bc_code,
    input  logic                         snp_valid,
    output logic                         snp_ready,
    input  logic [ADDR_W-1:0]            snp_addr,
    output logic [NUM_CORES-1:0]         core_snp_valid,
    output logic [ADDR_W-1:0]            core_snp_addr,
    input  logic [NUM_CORES-1:0]         csr_valid,
    input  logic [NUM_CORES-1:0]         csr_hit,
    input  logic [NUM_CORES-1:0]         csr_mod,
    output logic                         sock_valid,
    output logic                         sock_hit,
    output logic                         sock_mod
);
    logic [NUM_CORES-1:0] hv;
    logic [NUM_CORES-1:0] pop;
    logic [1:0]           hkind [NUM_CORES];
    logic [ADDR_W-1:0]    haddr [NUM_CORES];
    logic [DATA_W-1:0]    hdata [NUM_CORES];
    logic [TAG_W-1:0]     htag  [NUM_CORES];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        arb_core_queues #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .TAG_W    (TAG_W),
            .RDQ_DEPTH(RDQ_DEPTH),
            .WRQ_DEPTH(WRQ_DEPTH),
            .COQ_DEPTH(COQ_DEPTH),
            .WDB_DEPTH(WDB_DEPTH)
        ) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_valid(push_valid[c]),
            .push_kind (push_kind[2*c +: 2]),
            .push_addr (push_addr[ADDR_W*c +: ADDR_W]),
            .push_data (push_data[DATA_W*c +: DATA_W]),
            .push_tag  (push_tag[TAG_W*c +: TAG_W]),
            .pop       (pop[c]),
            .head_valid(hv[c]),
            .head_kind (hkind[c]),
            .head_addr (haddr[c]),
            .head_data (hdata[c]),
            .head_tag  (htag[c]),
            .crd_valid (crd_valid[c]),
            .crd_kind  (crd_kind[2*c +: 2]),
            .ovf       (ovf_err[c])
        );
    end

    // issue slot machine
    issue_state_e is_state, is_state_n;
    logic         pref;
    logic         pick;
    logic         load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            is_state <= IS_EMPTY;
        else
            is_state <= is_state_n;
    end

    always_comb begin
        pick = 1'b0;
        if (&hv)
            pick = pref;
        else if (hv[1])
            pick = 1'b1;
        load       = 1'b0;
        is_state_n = is_state;
        out_valid  = 1'b0;
        unique case (is_state)
            IS_EMPTY: begin
                if (|hv) begin
                    load       = 1'b1;
                    is_state_n = IS_HELD;
                end
            end
            IS_HELD: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    load       = |hv;
                    is_state_n = (|hv) ? IS_HELD : IS_EMPTY;
                end
            end
            default: is_state_n = IS_EMPTY;
        endcase
        pop = '0;
        pop[pick] = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pref     <= 1'b0;
            out_core <= 1'b0;
            out_kind <= K_READ;
            out_addr <= '0;
            out_data <= '0;
            out_tag  <= '0;
        end else if (load) begin
            pref     <= ~pick;
            out_core <= pick;
            out_kind <= hkind[pick];
            out_addr <= haddr[pick];
            out_data <= hdata[pick];
            out_tag  <= htag[pick];
        end
    end

    // response steering and broadcast fan-out
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_rsp_valid <= '0;
            core_rsp_tag   <= '0;
            core_rsp_data  <= '0;
            core_bc_valid  <= '0;
            core_bc_code   <= '0;
        end else begin
            core_rsp_valid <= '0;
            if (rsp_valid)
                core_rsp_valid[rsp_tag[TAG_W]] <= 1'b1;
            core_rsp_tag  <= rsp_tag[TAG_W-1:0];
            core_rsp_data <= rsp_data;
            core_bc_valid <= {NUM_CORES{bc_valid}};
            core_bc_code  <= bc_code;
        end
    end

    arb_snoop_merge #(
        .ADDR_W(ADDR_W)
    ) u_snoop (
        .clk           (clk),
        .rst_n         (rst_n),
        .snp_valid     (snp_valid),
        .snp_addr      (snp_addr),
        .snp_ready     (snp_ready),
        .core_snp_valid(core_snp_valid),
        .core_snp_addr (core_snp_addr),
        .csr_valid     (csr_valid),
        .csr_hit       (csr_hit),
        .csr_mod       (csr_mod),
        .sock_valid    (sock_valid),
        .sock_hit      (sock_hit),
        .sock_mod      (sock_mod)
    );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        crd_valid,
    input logic [3:0]        crd_kind,
    input logic [1:0]        ovf_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_core,
    input logic [1:0]        out_kind,
    input logic [ADDR_W-1:0] out_addr,
    input logic              rsp_valid,
    input logic [TAG_W:0]    rsp_tag,
    input logic [1:0]        core_rsp_valid,
    input logic              bc_valid,
    input logic [1:0]        core_bc_valid,
    input logic [1:0]        core_snp_valid,
    input logic              sock_valid
);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_core) && $stable(out_kind)));

    assert_crd0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crd_valid[0] |-> (out_valid && !out_core && crd_kind[1:0] == out_kind));

    assert_crd1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crd_valid[1] |-> (out_valid && out_core && crd_kind[3:2] == out_kind));

    assert_ovf_sticky0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err[0] |=> ovf_err[0]);

    assert_ovf_sticky1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err[1] |=> ovf_err[1]);

    assert_rsp_steer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (core_rsp_valid == ($past(rsp_tag[TAG_W]) ? 2'b10 : 2'b01)));

    assert_bc_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |=> (core_bc_valid == 2'b11));

    assert_snp_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_snp_valid[0] == core_snp_valid[1]);

    assert_sock_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sock_valid |=> !sock_valid);
endmodule

bind dual_core_sys_arbiter arb_checker #(
    .ADDR_W(ADDR_W),
    .TAG_W (TAG_W)
) u_chk (.*);

// File: tb/test_dual_core_sys_arbiter.sv
module test_dual_core_sys_arbiter;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int BC_W   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] push_valid = '0;
    logic [3:0] push_kind = '0;
    logic [2*ADDR_W-1:0] push_addr = '0;
    logic [2*DATA_W-1:0] push_data = '0;
    logic [2*TAG_W-1:0] push_tag = '0;
    logic [1:0] crd_valid;
    logic [3:0] crd_kind;
    logic [1:0] ovf_err;
    logic out_valid;
    logic out_ready = 1'b0;
    logic out_core;
    logic [1:0] out_kind;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic [TAG_W-1:0] out_tag;
    logic rsp_valid = 1'b0;
    logic [TAG_W:0] rsp_tag = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic [1:0] core_rsp_valid;
    logic [TAG_W-1:0] core_rsp_tag;
    logic [DATA_W-1:0] core_rsp_data;
    logic bc_valid = 1'b0;
    logic [BC_W-1:0] bc_code = '0;
    logic [1:0] core_bc_valid;
    logic [BC_W-1:0] core_bc_code;
    logic snp_valid = 1'b0;
    logic snp_ready;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [1:0] core_snp_valid;
    logic [ADDR_W-1:0] core_snp_addr;
    logic [1:0] csr_valid = '0;
    logic [1:0] csr_hit = '0;
    logic [1:0] csr_mod = '0;
    logic sock_valid;
    logic sock_hit;
    logic sock_mod;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dual_core_sys_arbiter i_dual_core_sys_arbiter (.*);

    // {c0 mask[38:35], c1 mask[34:31], count[30:27], order[26:0]}
    // mask bit = kind code; order entry i = {core, kind} at [3i+2:3i]
    localparam logic [38:0] VEC [5] = '{
        {4'b0011, 4'b0101, 4'd5, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd6, 3'd0, 3'd4, 3'd2},
        {4'b0000, 4'b1111, 4'd5, 3'd0, 3'd0, 3'd0, 3'd0, 3'd6, 3'd7, 3'd5, 3'd4, 3'd2},
        {4'b1110, 4'b0010, 4'd5, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd3, 3'd1, 3'd5, 3'd2},
        {4'b0001, 4'b0000, 4'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2},
        {4'b1111, 4'b1111, 4'd9, 3'd2, 3'd6, 3'd3, 3'd7, 3'd1, 3'd5, 3'd0, 3'd4, 3'd2}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nth_kind(input logic [3:0] m, input int n);
        int seen = 0;
        for (int b = 0; b < 4; b++) begin
            if (m[b]) begin
                if (seen == n) return b;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic clear_push();
        push_valid = '0;
    endtask

    task automatic drive_push(input int c, input logic [1:0] k,
                              input logic [15:0] a, input logic [3:0] t);
        push_valid[c]             = 1'b1;
        push_kind[2*c +: 2]       = k;
        push_addr[ADDR_W*c +: ADDR_W] = a;
        push_data[DATA_W*c +: DATA_W] = {16'hD0D0, a};
        push_tag[TAG_W*c +: TAG_W]    = t;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        // R12 reset state
        chk(!out_valid && crd_valid == 0 && ovf_err == 0 && core_rsp_valid == 0
            && core_bc_valid == 0 && core_snp_valid == 0 && !sock_valid && snp_ready,
            "R12 reset", {out_valid, crd_valid, ovf_err, sock_valid, snp_ready}, 64'h1);

        // table: ordering, alternation, lone-core streaming, hold
        for (int v = 0; v < 5; v++) begin
            logic [3:0] m0;
            logic [3:0] m1;
            int cnt;
            m0  = VEC[v][38:35];
            m1  = VEC[v][34:31];
            cnt = int'(VEC[v][30:27]);
            out_ready = 1'b0;
            drive_push(0, 2'd2, 16'h0F00, 4'h0);
            tick();
            clear_push();
            for (int s = 0; s < 4; s++) begin
                int k0;
                int k1;
                k0 = nth_kind(m0, s);
                k1 = nth_kind(m1, s);
                if (k0 >= 0) drive_push(0, 2'(k0), 16'(16'h0100 + s), 4'(s));
                if (k1 >= 0) drive_push(1, 2'(k1), 16'(16'h1100 + s), 4'(s));
                tick();
                clear_push();
            end
            tick();
            // R5 held slot still carries the lead castout of core 0
            chk(out_valid && !out_core && out_kind == 2'd2 && out_addr == 16'h0F00,
                "R5 hold", {out_valid, out_core, out_kind, out_addr}, {1'b1, 1'b0, 2'd2, 16'h0F00});
            out_ready = 1'b1;
            for (int i = 0; i < cnt; i++) begin
                logic [2:0] e;
                e = VEC[v][3*i +: 3];
                // R2 priority, R3 alternation, R4 lone core back to back
                chk(out_valid && {out_core, out_kind} == e, "R2/R3/R4 issue order",
                    {out_valid, out_core, out_kind}, {1'b1, e});
                tick();
            end
            out_ready = 1'b0;
            chk(!out_valid, "R4 drained", out_valid, 0);
        end

        // R6 credit return pulse
        out_ready = 1'b1;
        drive_push(1, 2'd1, 16'hABCD, 4'h9);
        tick();
        clear_push();
        chk(crd_valid == 2'b00, "R6 no early credit", crd_valid, 0);
        tick();
        chk(crd_valid == 2'b10 && crd_kind[3:2] == 2'd1, "R6 credit kind",
            {crd_valid, crd_kind}, {2'b10, 4'b0100});
        chk(out_valid && out_core && out_tag == 4'h9 && out_data == 32'hD0D0ABCD,
            "R8 out tag/data", {out_core, out_tag, out_data}, {1'b1, 4'h9, 32'hD0D0ABCD});
        tick();
        chk(crd_valid == 2'b00 && !out_valid, "R6 credit one cycle", crd_valid, 0);

        // R1 / R7 capacity and overflow on core 0 reads
        out_ready = 1'b0;
        for (int n = 1; n <= 5; n++) begin
            drive_push(0, 2'd0, 16'(n), 4'(n));
            tick();
        end
        clear_push();
        chk(ovf_err == 2'b00, "R1 five reads fit", ovf_err, 0);
        drive_push(0, 2'd0, 16'h0006, 4'h6);
        tick();
        clear_push();
        tick();
        chk(ovf_err == 2'b01, "R7 overflow flag", ovf_err, 1);
        out_ready = 1'b1;
        for (int n = 1; n <= 5; n++) begin
            chk(out_valid && out_addr == 16'(n), "R1 queued reads in order",
                out_addr, 64'(n));
            tick();
        end
        chk(!out_valid, "R7 dropped push absent", out_valid, 0);
        chk(ovf_err == 2'b01, "R7 flag sticky", ovf_err, 1);
        out_ready = 1'b0;

        // R8 response steering
        rsp_valid = 1'b1;
        rsp_tag   = {1'b1, 4'h5};
        rsp_data  = 32'h12345678;
        tick();
        rsp_valid = 1'b0;
        chk(core_rsp_valid == 2'b10 && core_rsp_tag == 4'h5 && core_rsp_data == 32'h12345678,
            "R8 to core1", {core_rsp_valid, core_rsp_tag}, {2'b10, 4'h5});
        rsp_valid = 1'b1;
        rsp_tag   = {1'b0, 4'hA};
        tick();
        rsp_valid = 1'b0;
        chk(core_rsp_valid == 2'b01 && core_rsp_tag == 4'hA, "R8 to core0",
            {core_rsp_valid, core_rsp_tag}, {2'b01, 4'hA});
        tick();
        chk(core_rsp_valid == 2'b00, "R8 pulse", core_rsp_valid, 0);

        // R9 broadcast
        bc_valid = 1'b1;
        bc_code  = 4'h6;
        tick();
        bc_valid = 1'b0;
        chk(core_bc_valid == 2'b11 && core_bc_code == 4'h6, "R9 broadcast",
            {core_bc_valid, core_bc_code}, {2'b11, 4'h6});

        // R10 / R11 snoop with simultaneous replies
        snp_valid = 1'b1;
        snp_addr  = 16'h4242;
        tick();
        snp_valid = 1'b0;
        chk(core_snp_valid == 2'b11 && core_snp_addr == 16'h4242 && !snp_ready,
            "R10 forward", {core_snp_valid, snp_ready}, {2'b11, 1'b0});
        csr_valid = 2'b11;
        csr_hit   = 2'b01;
        csr_mod   = 2'b00;
        tick();
        csr_valid = 2'b00;
        chk(sock_valid && sock_hit && !sock_mod, "R11 merged both",
            {sock_valid, sock_hit, sock_mod}, 3'b110);
        tick();
        chk(!sock_valid && snp_ready, "R11 single pulse", {sock_valid, snp_ready}, 2'b01);

        // R10 / R11 staggered replies, busy snoop ignored
        snp_valid = 1'b1;
        snp_addr  = 16'h0777;
        tick();
        snp_addr  = 16'h0999;
        csr_valid = 2'b10;
        csr_hit   = 2'b10;
        csr_mod   = 2'b10;
        tick();
        csr_valid = 2'b00;
        chk(!sock_valid && core_snp_valid == 2'b00 && !snp_ready,
            "R11 waits for second reply", {sock_valid, core_snp_valid}, 0);
        chk(core_snp_addr == 16'h0777, "R10 busy snoop ignored", core_snp_addr, 16'h0777);
        snp_valid = 1'b0;
        csr_valid = 2'b01;
        csr_hit   = 2'b00;
        csr_mod   = 2'b00;
        tick();
        csr_valid = 2'b00;
        chk(sock_valid && sock_hit && sock_mod, "R11 OR of flags",
            {sock_valid, sock_hit, sock_mod}, 3'b111);
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule